// File: doc/BRIEF.md
# Daisy-Chain Serial Frame Composer

This block is the host end of a 3-wire serial link feeding a chain of identical devices, each of which takes a 12-bit command word. A request carries, for every position in the chain, a two-bit address, a two-bit control field, an eight-bit data field and a valid bit. The block joins these into one frame of 12 bits per device. Every position whose valid bit is clear gets an all-zero no-operation word, so that device stays as it is.

The frame leaves most significant bit first, with the serial clock idling low. The device farthest from the host gets its word first. Chip select stays low for the whole frame without a break. It then rises once, and every device in the chain acts on its word at that same edge. The SCLK half period is set for each request from a divider input. A start/busy/done handshake paces the requests. The chain length is a parameter.

Top module: `dchain_frame_tx`

## Requirements
- R1: Each device word is sent as bit 11 = address[1], bit 10 = address[0], bit 9 = control[1], bit 8 = control[0], then data[7] down to data[0] in bits 7..0, most significant bit first.
- R2: One frame produces exactly 12*NDEV rising SCLK edges while cs_n is low.
- R3: The word of slot NDEV-1 (farthest from the host) is sent first and the word of slot 0 is sent last.
- R4: A slot whose valid_mask bit is 0 is sent as 12'h000 (address 00, control 00, data zero), whatever its address, control and data inputs hold.
- R5: cs_n falls once at the start of a frame and rises once at its end. SCLK is low whenever cs_n is high, and SCLK is low at both edges of cs_n.
- R6: din changes only on the clock edge where SCLK falls, or while SCLK is low. It is stable while SCLK is high, including at the SCLK rising edge.
- R7: Every SCLK high phase and every SCLK low phase lasts div_half+1 clock cycles. This includes the low lead from the cs_n fall to the first rise and the low tail from the last fall to the cs_n rise.
- R8: After cs_n rises, it stays high for 2*(div_half+1) clock cycles before done is raised. This is one full SCLK period.
- R9: start is accepted only while busy is low. busy rises in the cycle after the acceptance. A start while busy is ignored and changes neither the frame in flight nor what follows it. done is a one-cycle pulse, raised in the same cycle that busy falls.
- R10: While reset is asserted and right after it, cs_n is 1, sclk is 0, din is 0, busy is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| div_half | input | DIV_W | SCLK half period minus one, in clock cycles |
| valid_mask | input | NDEV | Per-slot update enable; 0 sends a no-op word |
| req_addr | input | 2*NDEV | Address fields, slot i at bits [2i+1:2i] |
| req_ctl | input | 2*NDEV | Control fields, slot i at bits [2i+1:2i] |
| req_data | input | 8*NDEV | Data fields, slot i at bits [8i+7:8i] |
| busy | output | 1 | High while a frame or its trailing gap is in progress |
| done | output | 1 | One-cycle pulse when the block returns to idle |
| sclk | output | 1 | Serial clock, idle low |
| din | output | 1 | Serial data toward the first device |
| cs_n | output | 1 | Active-low chip select shared by the chain |

## Verification
The bench builds the block with NDEV = 3 and DIV_W = 4. This gives a 36-bit frame in which the first, middle and last slots can each be masked or kept independently. The four-bit divider lets the bench cover both the fastest case (div_half = 0, a one-cycle half period) and the slowest case (div_half = 15) with short runs. Random masks and field values, together with directed all-masked, all-valid and single-slot frames, exercise the no-op fill and the slot ordering at every divider setting tried.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
   localparam int WORD_W = 12;
   localparam int ADDR_W = 2;
   localparam int CTL_W  = 2;
   localparam int DATA_W = 8;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [CTL_W-1:0]  ctl;
      logic [DATA_W-1:0] data;
   } dev_word_t;

   localparam dev_word_t NOP_WORD = '0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_TAIL,
      ST_GAPA,
      ST_GAPB
   } seq_state_t;
endpackage

// File: rtl/dchain_frame_build.sv
module dchain_frame_build
   import dchain_pkg::*;
#(
   parameter int NDEV = 3,
   localparam int FRAME_W = WORD_W * NDEV
) (
   input  logic [NDEV-1:0]        valid_mask,
   input  logic [ADDR_W*NDEV-1:0] req_addr,
   input  logic [CTL_W*NDEV-1:0]  req_ctl,
   input  logic [DATA_W*NDEV-1:0] req_data,
   output logic [FRAME_W-1:0]     frame
);
   // Slot g sits at bits [12g+11:12g]; the top slot leaves first.
   for (genvar g = 0; g < NDEV; g++) begin : g_slot
      dev_word_t word;
      assign word.addr = req_addr[g*ADDR_W +: ADDR_W];
      assign word.ctl  = req_ctl[g*CTL_W +: CTL_W];
      assign word.data = req_data[g*DATA_W +: DATA_W];
      assign frame[g*WORD_W +: WORD_W] = valid_mask[g] ? word : NOP_WORD;
   end
endmodule

// File: rtl/dchain_tick.sv
module dchain_tick #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         tick
);
   logic [W-1:0] cnt;

   assign tick = run && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
   import dchain_pkg::*;
#(
   parameter int NDEV  = 3,
   parameter int DIV_W = 8,
   localparam int FRAME_W = WORD_W * NDEV,
   localparam int BIT_W   = $clog2(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [DIV_W-1:0]   div_in,
   input  logic               tick,
   output logic               run,
   output logic [DIV_W-1:0]   lim,
   output logic               sclk,
   output logic               din,
   output logic               cs_n,
   output logic               busy,
   output logic               done
);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

   seq_state_t         state;
   logic [FRAME_W-1:0] shreg;
   logic [BIT_W-1:0]   bit_idx;

   assign run  = (state != ST_IDLE);
   assign busy = run;
   assign sclk = (state == ST_HIGH);
   assign cs_n = !((state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL));
   assign din  = shreg[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         shreg   <= '0;
         bit_idx <= '0;
         lim     <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  shreg   <= frame_in;
                  lim     <= div_in;
                  bit_idx <= '0;
                  state   <= ST_LOW;
               end
            end
            ST_LOW: begin
               if (tick) state <= ST_HIGH;
            end
            ST_HIGH: begin
               if (tick) begin
                  if (bit_idx == LAST_BIT) begin
                     state <= ST_TAIL;
                  end else begin
                     // next bit presented on the falling edge
                     shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                     bit_idx <= bit_idx + 1'b1;
                     state   <= ST_LOW;
                  end
               end
            end
            ST_TAIL: begin
               if (tick) state <= ST_GAPA;
            end
            ST_GAPA: begin
               if (tick) state <= ST_GAPB;
            end
            ST_GAPB: begin
               if (tick) begin
                  state <= ST_IDLE;
                  shreg <= '0;
                  done  <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dchain_frame_tx.sv
module dchain_frame_tx
   import dchain_pkg::*;
#(
   parameter int NDEV  = 3,
   parameter int DIV_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [DIV_W-1:0]       div_half,
   input  logic [NDEV-1:0]        valid_mask,
   input  logic [ADDR_W*NDEV-1:0] req_addr,
   input  logic [CTL_W*NDEV-1:0]  req_ctl,
   input  logic [DATA_W*NDEV-1:0] req_data,
   output logic                   busy,
   output logic                   done,
   output logic                   sclk,
   output logic                   din,
   output logic                   cs_n
);
   localparam int FRAME_W = WORD_W * NDEV;

   if (NDEV < 1) begin : g_bad_ndev
      $error("dchain_frame_tx: NDEV must be at least 1");
   end
   if (DIV_W < 1) begin : g_bad_divw
      $error("dchain_frame_tx: DIV_W must be at least 1");
   end

   logic [FRAME_W-1:0] frame;
   logic               tick;
   logic               run;
   logic [DIV_W-1:0]   lim;

   dchain_frame_build #(.NDEV(NDEV)) i_build (
      .valid_mask (valid_mask),
      .req_addr   (req_addr),
      .req_ctl    (req_ctl),
      .req_data   (req_data),
      .frame      (frame)
   );

   dchain_tick #(.W(DIV_W)) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .limit (lim),
      .tick  (tick)
   );

   dchain_seq #(.NDEV(NDEV), .DIV_W(DIV_W)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .frame_in (frame),
      .div_in   (div_half),
      .tick     (tick),
      .run      (run),
      .lim      (lim),
      .sclk     (sclk),
      .din      (din),
      .cs_n     (cs_n),
      .busy     (busy),
      .done     (done)
   );
endmodule

// File: rtl/dchain_frame_tx_chk.sv
module dchain_frame_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic sclk,
   input logic din,
   input logic cs_n
);
   // R5: clock held low while deselected
   a_r5_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R5: select edges only with the clock low
   a_r5_cs_rise_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> ($past(sclk) == 1'b0));

   // R6: data stable while the clock is high
   a_r6_din_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(din));

   // R8: at least two cycles of deselect before completion
   a_r8_cs_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> (cs_n && !done));

   // R9: done is a single-cycle pulse that ends busy
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R9: busy only rises after an accepted start
   a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R9: idle block keeps the link quiet
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && !sclk));
endmodule

bind dchain_frame_tx dchain_frame_tx_chk i_chk (.*);

// File: tb/test_dchain_frame_tx.sv
`timescale 1ns/1ps
module test_dchain_frame_tx;
   localparam int NDEV  = 3;
   localparam int DIV_W = 4;
   localparam int FW    = 12 * NDEV;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [DIV_W-1:0]  div_half = '0;
   logic [NDEV-1:0]   valid_mask = '0;
   logic [2*NDEV-1:0] req_addr = '0;
   logic [2*NDEV-1:0] req_ctl = '0;
   logic [8*NDEV-1:0] req_data = '0;
   logic busy, done, sclk, din, cs_n;

   int total = 0;
   int bad = 0;
   int cur_h = 1;

   always #4 clk = ~clk;

   dchain_frame_tx #(.NDEV(NDEV), .DIV_W(DIV_W)) i_dchain_frame_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .div_half(div_half),
      .valid_mask(valid_mask), .req_addr(req_addr), .req_ctl(req_ctl),
      .req_data(req_data), .busy(busy), .done(done), .sclk(sclk),
      .din(din), .cs_n(cs_n)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] exp_frame(
      input logic [NDEV-1:0] m, input logic [2*NDEV-1:0] a,
      input logic [2*NDEV-1:0] c, input logic [8*NDEV-1:0] d);
      logic [FW-1:0] f;
      for (int i = 0; i < NDEV; i++) begin
         f[12*i +: 12] = m[i] ? {a[2*i +: 2], c[2*i +: 2], d[8*i +: 8]} : 12'h000;
      end
      return f;
   endfunction

   // link monitor
   logic          p_sclk = 1'b0, p_cs = 1'b1, p_din = 1'b0;
   logic [FW-1:0] cap = '0, got_frame = '0;
   int            nbits = 0, got_bits = 0, run_len = 0, gap = 0, cs_falls = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n) begin
            if (p_cs) begin
               run_len = 1;
               nbits = 0;
               cs_falls++;
               chk(!sclk, "R5 sclk low at cs fall", sclk, 0);
            end else if (sclk != p_sclk) begin
               chk(run_len == cur_h, "R7 phase length", run_len, cur_h);
               run_len = 1;
            end else begin
               run_len++;
            end
            if (sclk && !p_sclk) begin
               cap = {cap[FW-2:0], din};
               nbits++;
            end
            if (sclk && p_sclk && !p_cs)
               chk(din == p_din, "R6 din stable while sclk high", din, p_din);
         end else begin
            if (!p_cs) begin
               chk(run_len == cur_h, "R7 tail length", run_len, cur_h);
               chk(!p_sclk, "R5 sclk low at cs rise", p_sclk, 0);
               got_frame = cap;
               got_bits = nbits;
               gap = 1;
            end else if (done) begin
               chk(gap == 2 * cur_h, "R8 cs high gap", gap, 2 * cur_h);
            end else begin
               gap++;
            end
            if (sclk) chk(1'b0, "R5 sclk high while deselected", sclk, 0);
         end
      end
      p_sclk = sclk;
      p_cs = cs_n;
      p_din = din;
   end

   task automatic send(input logic [NDEV-1:0] m, input logic [2*NDEV-1:0] a,
                       input logic [2*NDEV-1:0] c, input logic [8*NDEV-1:0] d,
                       input logic [DIV_W-1:0] dv, input bit poke);
      logic [FW-1:0] e;
      int falls0;
      e = exp_frame(m, a, c, d);
      @(negedge clk);
      valid_mask = m; req_addr = a; req_ctl = c; req_data = d; div_half = dv;
      cur_h = int'(dv) + 1;
      falls0 = cs_falls;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R9 busy after accepted start", busy, 1);
      if (poke) begin
         repeat (10) @(negedge clk);
         valid_mask = ~m; req_addr = ~a; req_ctl = ~c; req_data = ~d; div_half = ~dv;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk(!busy, "R9 busy low with done", busy, 0);
      @(negedge clk);
      chk(!done, "R9 done one cycle", done, 0);
      chk(got_bits == FW, "R2 rising edges per frame", got_bits, FW);
      chk(got_frame == e, "R1 R3 R4 frame content", got_frame, e);
      chk(cs_falls == falls0 + 1, "R5 single cs fall", cs_falls, falls0 + 1);
      if (poke) begin
         repeat (4 * cur_h + 4) @(negedge clk);
         chk(!busy && cs_n, "R9 start while busy ignored", {busy, cs_n}, 2'b01);
      end
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      logic [NDEV-1:0]   m;
      logic [2*NDEV-1:0] a, c;
      logic [8*NDEV-1:0] d;
      logic [DIV_W-1:0]  dv;
      seed = 32'd4711;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(cs_n == 1'b1, "R10 cs_n in reset", cs_n, 1);
      chk(sclk == 1'b0, "R10 sclk in reset", sclk, 0);
      chk(din == 1'b0, "R10 din in reset", din, 0);
      chk(busy == 1'b0, "R10 busy in reset", busy, 0);
      chk(done == 1'b0, "R10 done in reset", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n && !sclk && !busy && !done && !din, "R10 after reset",
          {cs_n, sclk, busy, done, din}, 5'b10000);

      // directed: R1 layout, all slots valid, fastest clock
      send(3'b111, 6'b10_01_11, 6'b01_11_10, 24'hA5_3C_F0, 4'd0, 1'b0);
      // R4 all masked: frame of no-ops despite non-zero fields
      send(3'b000, 6'b111111, 6'b111111, 24'hFF_FF_FF, 4'd1, 1'b0);
      // R3 only farthest slot, then only nearest slot
      send(3'b100, 6'b11_00_00, 6'b10_00_00, 24'h81_00_00, 4'd2, 1'b0);
      send(3'b001, 6'b11_11_01, 6'b11_11_01, 24'h55_66_81, 4'd3, 1'b0);
      // R7 R8 slowest clock
      send(3'b101, 6'b01_10_11, 6'b11_01_10, 24'h12_34_56, 4'd15, 1'b0);
      // R9 start during a frame is ignored
      send(3'b011, 6'b00_11_10, 6'b00_01_11, 24'h00_C3_7E, 4'd1, 1'b1);

      for (int k = 0; k < 20; k++) begin
         m  = NDEV'($urandom);
         a  = (2*NDEV)'($urandom);
         c  = (2*NDEV)'($urandom);
         d  = (8*NDEV)'($urandom);
         dv = (k % 5 == 4) ? DIV_W'($urandom) : DIV_W'($urandom % 3);
         send(m, a, c, d, dv, (k % 7 == 3));
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule